// File: doc/BRIEF.md
# Phase-Aligned Two-Channel Bus-Stealing DMA Controller

This block sits beside a CPU core and takes over its bus for two kinds of transfer. The block copy channel moves one full source page of 256 bytes into a sprite-attribute memory port, one read and one write per byte. The sample channel fetches a single byte for an audio unit. Every clock is one CPU cycle. A one-bit cycle phase alternates between get and put. Both channels line up their first bus access with that phase by inserting halt, dummy and alignment cycles. While either channel is working, the block holds the CPU in a stall and issues at most one bus operation per cycle.

The sample channel always wins the bus. If a sample fetch arrives during a block copy, the copy freezes where it is. It picks up again at the same byte once the fetch has completed. Each bus operation is retired by a one-cycle completion strobe from the memory side. A read's data is taken on the same cycle as its strobe. Without the strobe the channel repeats the same operation.

Copy engine states: HALT, ALIGN, READ, WRITE. The transitions are HALT→ALIGN on a get cycle, HALT→READ on a put cycle, ALIGN→READ, READ→WRITE on the strobe, WRITE→READ on the strobe when the index has not wrapped, and WRITE→idle on the strobe at the last index. Sample engine states: WAIT, DUMMY, ALIGN, READ. The transitions are WAIT→DUMMY on the phase that matches the kind, DUMMY→READ on a put cycle, DUMMY→ALIGN on a get cycle, ALIGN→READ, and READ→idle on the strobe.

Top module: `stall_dma_ctrl`

## Requirements
- R1: The cycle phase starts as get (0) after reset and flips on every clock. Every decision in a cycle uses the phase value from the start of that cycle.
- R2: A copy request stores its page as pending, and the pending copy becomes visible on the next cycle. A pending copy starts only in a cycle where no copy is active and the sample channel is idle. A new request overwrites any pending page, and that page is copied after the current copy ends.
- R3: The first cycle of a copy is a halt. A halt on a get cycle adds one alignment cycle before the first read. A halt on a put cycle goes straight to a read on the next cycle.
- R4: A copy read addresses {page, index}, with the page in bits 15:8 and the index in bits 7:0. The byte returned is held, and the following write cycle presents it on bus_wdata.
- R5: Each completed write increments the index modulo 256. The copy ends after the write at index 255, so each copy performs exactly 256 read/write pairs starting at index 0.
- R6: A sample request (kind 0 = load, kind 1 = reload) is accepted only while no sample transfer is active. A request made while a transfer is active is ignored. A load halts in a get cycle and a reload halts in a put cycle. The request cycle itself counts, either as the halt or as the first waiting cycle.
- R7: The cycle after the halt is a dummy cycle. A dummy cycle in a put cycle is followed by the read. A dummy cycle in a get cycle is followed by one alignment cycle, then the read. The read completes on the strobe and frees the channel.
- R8: While the sample channel is active it owns every cycle and the copy state does not change. Afterwards the copy continues with the next pending operation.
- R9: cpu_stall is high in every cycle in which either channel is working, including halt, wait, dummy and alignment cycles and the cycle of a new request.
- R10: dma_busy is high whenever a copy is pending, a copy is active, or a sample transfer is active. It is driven from registered state.
- R11: bus_op is one-hot: bit 0 means no operation, bit 1 a sample read, bit 2 a copy read, bit 3 a copy write. bus_addr and bus_wdata are zero when unused. A read or write only advances its channel in a cycle where bus_done is high.
- R12: Synchronous reset clears the pending copy, both channels, the latch and the index, and sets the phase to get. After reset, cpu_stall and dma_busy are low and bus_op is 4'b0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU cycle clock |
| rst | input | 1 | Synchronous reset, active high |
| copy_req | input | 1 | Request a page copy this cycle |
| copy_page | input | 8 | Source page of the copy |
| smp_req | input | 1 | Request a sample fetch this cycle |
| smp_addr | input | 16 | Address of the sample byte |
| smp_kind | input | 1 | 0 = load (halts on get), 1 = reload (halts on put) |
| bus_done | input | 1 | Completion strobe for the operation presented this cycle |
| bus_rdata | input | 8 | Read data, valid with bus_done |
| cpu_stall | output | 1 | Holds the CPU this cycle |
| dma_busy | output | 1 | Pending or active work |
| bus_op | output | 4 | One-hot operation code |
| bus_addr | output | 16 | Read address |
| bus_wdata | output | 8 | Byte written to the sprite port |

## Verification
A corrupt phase bit moves every halt decision by one cycle. That shows up as a one-cycle shift of the first bus_op of the next transfer, so it is visible within the first few cycles of any request. A wrong index or latch appears at once on bus_addr or bus_wdata during the copy. A wrong hold during preemption shows up as a repeated or skipped address after the sample read. A broken pending or busy register changes cpu_stall or dma_busy on the very next cycle. The bench compares all outputs against a cycle model on every cycle, and that model has the bus responding with random completion delays.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic {
        PH_GET = 1'b0,
        PH_PUT = 1'b1
    } phase_e;

    typedef enum logic [1:0] {
        CP_HALT  = 2'd0,
        CP_ALIGN = 2'd1,
        CP_READ  = 2'd2,
        CP_WRITE = 2'd3
    } copy_st_e;

    typedef enum logic [1:0] {
        SM_WAIT  = 2'd0,
        SM_DUMMY = 2'd1,
        SM_ALIGN = 2'd2,
        SM_READ  = 2'd3
    } smp_st_e;

    localparam int OP_W       = 4;
    localparam int OP_IDLE_B  = 0;
    localparam int OP_SRD_B   = 1;
    localparam int OP_CRD_B   = 2;
    localparam int OP_CWR_B   = 3;

endpackage

// File: rtl/dma_phase_gen.sv
module dma_phase_gen
    import dma_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e phase
);

    phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_GET;
        end else begin
            phase_q <= (phase_q == PH_GET) ? PH_PUT : PH_GET;
        end
    end

    assign phase = phase_q;

endmodule

// File: rtl/dma_sample_eng.sv
module dma_sample_eng
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_kind,
    input  logic              done,
    output logic              run,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              active
);

    logic              active_q, active_n;
    smp_st_e           st_q, st_n, st_cur;
    logic [ADDR_W-1:0] addr_q, addr_n, addr_cur;
    logic              kind_q, kind_n, kind_cur;

    // current view: a new request behaves as a WAIT state this cycle
    always_comb begin
        run      = active_q || req;
        st_cur   = active_q ? st_q : SM_WAIT;
        addr_cur = active_q ? addr_q : req_addr;
        kind_cur = active_q ? kind_q : req_kind;
    end

    // next-state logic
    always_comb begin
        active_n = active_q;
        st_n     = st_q;
        addr_n   = addr_q;
        kind_n   = kind_q;
        if (run) begin
            active_n = 1'b1;
            addr_n   = addr_cur;
            kind_n   = kind_cur;
            unique case (st_cur)
                SM_WAIT: begin
                    st_n = (logic'(phase) == kind_cur) ? SM_DUMMY : SM_WAIT;
                end
                SM_DUMMY: begin
                    st_n = (phase == PH_PUT) ? SM_READ : SM_ALIGN;
                end
                SM_ALIGN: begin
                    st_n = SM_READ;
                end
                SM_READ: begin
                    if (done) begin
                        active_n = 1'b0;
                        st_n     = SM_WAIT;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            st_q     <= SM_WAIT;
            addr_q   <= '0;
            kind_q   <= 1'b0;
        end else begin
            active_q <= active_n;
            st_q     <= st_n;
            addr_q   <= addr_n;
            kind_q   <= kind_n;
        end
    end

    // outputs
    always_comb begin
        rd_req  = run && (st_cur == SM_READ);
        rd_addr = rd_req ? addr_cur : '0;
        active  = active_q;
    end

    // R6
    smp_halt_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (run && st_cur == SM_WAIT && logic'(phase) == kind_cur)
            |=> (active_q && st_q == SM_DUMMY));

    // R6
    smp_ignore_req_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && st_q != SM_READ) |=> (active_q && $stable(addr_q)));

    // R7
    smp_dummy_put_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && st_q == SM_DUMMY && phase == PH_PUT) |=> (st_q == SM_READ));

endmodule

// File: rtl/dma_copy_eng.sv
module dma_copy_eng
    import dma_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  phase_e                  phase,
    input  logic                    hold,
    input  logic                    pend_valid,
    input  logic [PAGE_W-1:0]       pend_page,
    input  logic                    done,
    input  logic [DATA_W-1:0]       rdata,
    output logic                    start,
    output logic                    run,
    output logic                    rd_req,
    output logic                    wr_req,
    output logic [PAGE_W+IDX_W-1:0] rd_addr,
    output logic [DATA_W-1:0]       wr_data,
    output logic                    active
);

    localparam logic [IDX_W-1:0] IDX_LAST = '1;

    logic              active_q, active_n;
    copy_st_e          st_q, st_n, st_cur;
    logic [PAGE_W-1:0] page_q, page_n, page_cur;
    logic [IDX_W-1:0]  idx_q, idx_n;
    logic [DATA_W-1:0] latch_q, latch_n;

    always_comb begin
        start    = !hold && !active_q && pend_valid;
        run      = !hold && (active_q || pend_valid);
        st_cur   = active_q ? st_q : CP_HALT;
        page_cur = active_q ? page_q : pend_page;
    end

    // next-state logic
    always_comb begin
        active_n = active_q;
        st_n     = st_q;
        page_n   = page_q;
        idx_n    = idx_q;
        latch_n  = latch_q;
        if (run) begin
            active_n = 1'b1;
            page_n   = page_cur;
            if (start) begin
                idx_n = '0;
            end
            unique case (st_cur)
                CP_HALT: begin
                    st_n = (phase == PH_GET) ? CP_ALIGN : CP_READ;
                end
                CP_ALIGN: begin
                    st_n = CP_READ;
                end
                CP_READ: begin
                    if (done) begin
                        latch_n = rdata;
                        st_n    = CP_WRITE;
                    end
                end
                CP_WRITE: begin
                    if (done) begin
                        idx_n = idx_q + 1'b1;
                        if (idx_q == IDX_LAST) begin
                            active_n = 1'b0;
                            st_n     = CP_HALT;
                        end else begin
                            st_n = CP_READ;
                        end
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            st_q     <= CP_HALT;
            page_q   <= '0;
            idx_q    <= '0;
            latch_q  <= '0;
        end else begin
            active_q <= active_n;
            st_q     <= st_n;
            page_q   <= page_n;
            idx_q    <= idx_n;
            latch_q  <= latch_n;
        end
    end

    // outputs
    always_comb begin
        rd_req  = run && (st_cur == CP_READ);
        wr_req  = run && (st_cur == CP_WRITE);
        rd_addr = rd_req ? {page_q, idx_q} : '0;
        wr_data = wr_req ? latch_q : '0;
        active  = active_q;
    end

    // R8
    copy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hold && active_q) |=> (active_q && $stable(idx_q) && $stable(st_q) && $stable(page_q)));

    // R5
    copy_wrap_end_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_req && done && idx_q == IDX_LAST) |=> (!active_q && idx_q == '0));

    // R5
    copy_idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_req && done && idx_q != IDX_LAST) |=> (idx_q == $past(idx_q) + 1'b1 && st_q == CP_READ));

endmodule

// File: rtl/stall_dma_ctrl.sv
module stall_dma_ctrl
    import dma_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    copy_req,
    input  logic [PAGE_W-1:0]       copy_page,
    input  logic                    smp_req,
    input  logic [PAGE_W+IDX_W-1:0] smp_addr,
    input  logic                    smp_kind,
    input  logic                    bus_done,
    input  logic [DATA_W-1:0]       bus_rdata,
    output logic                    cpu_stall,
    output logic                    dma_busy,
    output logic [OP_W-1:0]         bus_op,
    output logic [PAGE_W+IDX_W-1:0] bus_addr,
    output logic [DATA_W-1:0]       bus_wdata
);

    localparam int ADDR_W = PAGE_W + IDX_W;

    phase_e            phase;
    logic              pend_v;
    logic [PAGE_W-1:0] pend_pg;

    logic              sm_run, sm_rd, sm_active;
    logic [ADDR_W-1:0] sm_addr;
    logic              cp_start, cp_run, cp_rd, cp_wr, cp_active;
    logic [ADDR_W-1:0] cp_addr;
    logic [DATA_W-1:0] cp_wdata;

    dma_phase_gen u_phase (
        .clk   (clk),
        .rst   (rst),
        .phase (phase)
    );

    dma_sample_eng #(
        .ADDR_W (ADDR_W)
    ) u_smp (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .req      (smp_req),
        .req_addr (smp_addr),
        .req_kind (smp_kind),
        .done     (bus_done),
        .run      (sm_run),
        .rd_req   (sm_rd),
        .rd_addr  (sm_addr),
        .active   (sm_active)
    );

    dma_copy_eng #(
        .PAGE_W (PAGE_W),
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) u_copy (
        .clk        (clk),
        .rst        (rst),
        .phase      (phase),
        .hold       (sm_run),
        .pend_valid (pend_v),
        .pend_page  (pend_pg),
        .done       (bus_done),
        .rdata      (bus_rdata),
        .start      (cp_start),
        .run        (cp_run),
        .rd_req     (cp_rd),
        .wr_req     (cp_wr),
        .rd_addr    (cp_addr),
        .wr_data    (cp_wdata),
        .active     (cp_active)
    );

    // pending copy register: a new request wins over consumption
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v  <= 1'b0;
            pend_pg <= '0;
        end else if (copy_req) begin
            pend_v  <= 1'b1;
            pend_pg <= copy_page;
        end else if (cp_start) begin
            pend_v  <= 1'b0;
        end
    end

    // bus and status outputs
    always_comb begin
        cpu_stall = sm_run || cp_run;
        dma_busy  = pend_v || cp_active || sm_active;
        bus_op    = '0;
        bus_addr  = '0;
        bus_wdata = '0;
        if (sm_rd) begin
            bus_op[OP_SRD_B] = 1'b1;
            bus_addr         = sm_addr;
        end else if (cp_rd) begin
            bus_op[OP_CRD_B] = 1'b1;
            bus_addr         = cp_addr;
        end else if (cp_wr) begin
            bus_op[OP_CWR_B] = 1'b1;
            bus_wdata        = cp_wdata;
        end else begin
            bus_op[OP_IDLE_B] = 1'b1;
        end
    end

    // R11
    bus_op_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot(bus_op));

    // R9
    stall_when_active_chk: assert property (@(posedge clk) disable iff (rst)
        (cp_active || sm_active) |-> cpu_stall);

    // R10
    busy_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (copy_req && !sm_run) |=> dma_busy);

    // R1
    phase_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_GET) |=> (phase == PH_PUT));

endmodule

// File: tb/stall_dma_ctrl_tb.sv
module stall_dma_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        copy_req = 1'b0;
    logic [7:0]  copy_page = '0;
    logic        smp_req = 1'b0;
    logic [15:0] smp_addr = '0;
    logic        smp_kind = 1'b0;
    logic        bus_done = 1'b0;
    logic [7:0]  bus_rdata = '0;
    logic        cpu_stall;
    logic        dma_busy;
    logic [3:0]  bus_op;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    stall_dma_ctrl u_dut (
        .clk       (clk),
        .rst       (rst),
        .copy_req  (copy_req),
        .copy_page (copy_page),
        .smp_req   (smp_req),
        .smp_addr  (smp_addr),
        .smp_kind  (smp_kind),
        .bus_done  (bus_done),
        .bus_rdata (bus_rdata),
        .cpu_stall (cpu_stall),
        .dma_busy  (dma_busy),
        .bus_op    (bus_op),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // reference model state
    logic       m_ph, m_pv, m_ca, m_sa, m_sk;
    logic [7:0] m_pp, m_cp, m_ci, m_cl;
    logic [1:0] m_cs, m_ss;
    logic [15:0] m_sad;

    // observations
    logic       d_stall;
    logic [7:0] wlog [0:1023];
    int         wlog_n;
    logic [15:0] last_srd;

    function automatic logic [7:0] memv(input logic [15:0] a);
        logic [15:0] t;
        t = a * 16'd37 + 16'd11;
        return t[7:0] ^ a[15:8];
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
            summary();
        end
    end

    task automatic model_reset();
        m_ph = 0; m_pv = 0; m_ca = 0; m_sa = 0; m_sk = 0;
        m_pp = 0; m_cp = 0; m_ci = 0; m_cl = 0; m_cs = 0; m_ss = 0; m_sad = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        copy_req = 0; smp_req = 0; bus_done = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    // one CPU cycle; entered and left at a falling edge
    task automatic tick(input logic cr, input logic [7:0] cpg, input logic sr,
                        input logic [15:0] sad, input logic sk, input logic dn);
        logic e_stall, e_busy, start;
        logic [3:0] e_op;
        logic [15:0] e_addr, saddr;
        logic [7:0] e_wd, cpg_c, rd;
        logic [1:0] sst, cst;
        logic skind;
        logic n_ph, n_pv, n_ca, n_sa, n_sk;
        logic [7:0] n_pp, n_cp, n_ci, n_cl;
        logic [1:0] n_cs, n_ss;
        logic [15:0] n_sad;
        n_ph = ~m_ph; n_pv = m_pv; n_ca = m_ca; n_sa = m_sa; n_sk = m_sk;
        n_pp = m_pp; n_cp = m_cp; n_ci = m_ci; n_cl = m_cl; n_cs = m_cs; n_ss = m_ss; n_sad = m_sad;
        e_busy = m_pv | m_ca | m_sa;
        e_stall = 0; e_op = 4'b0001; e_addr = 0; e_wd = 0;
        rd = 8'h00;
        if (m_sa || sr) begin
            e_stall = 1;
            sst = m_sa ? m_ss : 2'd0;
            skind = m_sa ? m_sk : sk;
            saddr = m_sa ? m_sad : sad;
            n_sa = 1; n_sk = skind; n_sad = saddr;
            case (sst)
                2'd0: n_ss = (m_ph == skind) ? 2'd1 : 2'd0;
                2'd1: n_ss = m_ph ? 2'd3 : 2'd2;
                2'd2: n_ss = 2'd3;
                default: begin
                    e_op = 4'b0010; e_addr = saddr;
                    if (dn) begin n_sa = 0; n_ss = 0; end
                end
            endcase
        end else if (m_ca || m_pv) begin
            e_stall = 1;
            start = !m_ca;
            cst = m_ca ? m_cs : 2'd0;
            cpg_c = m_ca ? m_cp : m_pp;
            n_ca = 1; n_cp = cpg_c;
            if (start) begin n_ci = 0; n_pv = 0; end
            case (cst)
                2'd0: n_cs = (m_ph == 1'b0) ? 2'd1 : 2'd2;
                2'd1: n_cs = 2'd2;
                2'd2: begin
                    e_op = 4'b0100; e_addr = {cpg_c, m_ci};
                    rd = memv(e_addr);
                    if (dn) begin n_cl = rd; n_cs = 2'd3; end
                end
                default: begin
                    e_op = 4'b1000; e_wd = m_cl;
                    if (dn) begin
                        n_ci = m_ci + 8'd1;
                        if (m_ci == 8'hFF) begin n_ca = 0; n_cs = 0; end
                        else n_cs = 2'd2;
                    end
                end
            endcase
        end
        if (cr) begin n_pv = 1; n_pp = cpg; end
        if (e_op == 4'b0010) rd = memv(e_addr);

        copy_req = cr; copy_page = cpg; smp_req = sr; smp_addr = sad; smp_kind = sk;
        bus_done = dn; bus_rdata = rd;
        #1;
        chk(cpu_stall === e_stall, "R9 stall", 32'(cpu_stall), 32'(e_stall));
        chk(dma_busy === e_busy, "R10 busy", 32'(dma_busy), 32'(e_busy));
        chk(bus_op === e_op, "R11 bus_op", 32'(bus_op), 32'(e_op));
        chk(bus_addr === e_addr, "R4/R6 bus_addr", 32'(bus_addr), 32'(e_addr));
        chk(bus_wdata === e_wd, "R4 bus_wdata", 32'(bus_wdata), 32'(e_wd));
        d_stall = cpu_stall;
        if (bus_op == 4'b1000 && dn && wlog_n < 1024) begin
            wlog[wlog_n] = bus_wdata;
            wlog_n++;
        end
        if (bus_op == 4'b0010 && dn) last_srd = bus_addr;
        m_ph = n_ph; m_pv = n_pv; m_ca = n_ca; m_sa = n_sa; m_sk = n_sk;
        m_pp = n_pp; m_cp = n_cp; m_ci = n_ci; m_cl = n_cl; m_cs = n_cs; m_ss = n_ss; m_sad = n_sad;
        @(negedge clk);
    endtask

    task automatic idle(input logic dn);
        tick(0, 8'h00, 0, 16'h0000, 0, dn);
    endtask

    task automatic drain();
        for (int i = 0; i < 4000 && (m_pv || m_ca || m_sa); i++) idle(1);
        idle(1);
    endtask

    // sample fetch length from a chosen phase
    task automatic sample_len(input logic kind, input logic ph);
        int len, exp;
        while (m_ph != ph) idle(1);
        tick(0, 8'h00, 1, 16'hC0DE, kind, 1);
        len = 1;
        while (d_stall && len < 20) begin idle(1); if (d_stall) len++; end
        exp = ((ph != kind) ? 1 : 0) + 3 + (kind ? 1 : 0);
        chk(len == exp, kind ? "R1/R6/R7 reload length" : "R1/R6/R7 load length", 32'(len), 32'(exp));
        chk(last_srd == 16'hC0DE, "R6 sample address", 32'(last_srd), 32'hC0DE);
    endtask

    // full copy from a chosen start phase
    task automatic copy_len(input logic [7:0] pg, input logic start_ph);
        int len, exp, bad;
        while (m_ph == start_ph) idle(1);
        wlog_n = 0;
        tick(1, pg, 0, 16'h0000, 0, 1);
        len = 0;
        idle(1);
        while (d_stall && len < 700) begin len++; idle(1); end
        exp = 513 + ((start_ph == 1'b0) ? 1 : 0);
        chk(len == exp, "R3 copy stall length", 32'(len), 32'(exp));
        chk(wlog_n == 256, "R5 write count", 32'(wlog_n), 32'd256);
        bad = 0;
        for (int i = 0; i < 256; i++) if (wlog[i] !== memv({pg, 8'(i)})) bad++;
        chk(bad == 0, "R4 copied data", 32'(bad), 32'd0);
    endtask

    initial begin
        int bad;
        logic [15:0] first_addr;
        void'($urandom(32'd20240517));
        wlog_n = 0;
        last_srd = 0;
        d_stall = 0;
        do_reset();

        // R12 reset state
        #1;
        chk(cpu_stall === 1'b0, "R12 reset stall", 32'(cpu_stall), 32'd0);
        chk(dma_busy === 1'b0, "R12 reset busy", 32'(dma_busy), 32'd0);
        chk(bus_op === 4'b0001, "R12 reset op", 32'(bus_op), 32'd1);
        @(negedge clk);
        model_reset();
        m_ph = 1'b1;   // one clock edge passed since reset release
        idle(1);

        // R6 R7 phase-dependent sample timing
        sample_len(1'b0, 1'b0);
        sample_len(1'b0, 1'b1);
        sample_len(1'b1, 1'b1);
        sample_len(1'b1, 1'b0);

        // R6 second request while active is ignored
        tick(0, 8'h00, 1, 16'h1234, 1, 1);
        first_addr = 16'h1234;
        tick(0, 8'h00, 1, 16'hABCD, 0, 1);
        tick(0, 8'h00, 1, 16'h5555, 0, 1);
        for (int i = 0; i < 6 && m_sa; i++) idle(1);
        chk(last_srd == first_addr, "R6 ignored request", 32'(last_srd), 32'(first_addr));
        drain();

        // R3 R4 R5 copies from each start phase
        copy_len(8'h3C, 1'b0);
        copy_len(8'hA7, 1'b1);

        // R8 preemption during a copy
        wlog_n = 0;
        tick(1, 8'h52, 0, 16'h0000, 0, 1);
        for (int i = 0; i < 41; i++) idle(1);
        tick(0, 8'h00, 1, 16'h7F00, 0, 1);
        for (int i = 0; i < 150; i++) idle(($urandom % 4) != 0);
        tick(0, 8'h00, 1, 16'h7F01, 1, 1);
        drain();
        bad = 0;
        for (int i = 0; i < 256; i++) if (wlog[i] !== memv({8'h52, 8'(i)})) bad++;
        chk(wlog_n == 256 && bad == 0, "R8 copy after preemption", 32'(bad), 32'd0);

        // R2 overwrite of pending page during a copy
        wlog_n = 0;
        tick(1, 8'h10, 0, 16'h0000, 0, 1);
        for (int i = 0; i < 20; i++) idle(1);
        tick(1, 8'h20, 0, 16'h0000, 0, 1);
        for (int i = 0; i < 10; i++) idle(1);
        tick(1, 8'h30, 0, 16'h0000, 0, 1);
        drain();
        bad = 0;
        for (int i = 0; i < 256; i++) if (wlog[256+i] !== memv({8'h30, 8'(i)})) bad++;
        chk(wlog_n == 512 && bad == 0, "R2 overwritten pending page", 32'(wlog_n), 32'd512);

        // R11 withheld strobes, R8 random mix
        for (int i = 0; i < 20000; i++) begin
            tick(($urandom % 900) == 0, 8'($urandom), ($urandom % 30) == 0,
                 16'($urandom), 1'($urandom), ($urandom % 8) != 0);
        end
        drain();
        #1;
        chk(dma_busy === 1'b0 && cpu_stall === 1'b0, "R10 idle at end", 32'(dma_busy), 32'd0);

        summary();
    end

endmodule